// File: doc/BRIEF.md
# Acknowledgement Wait and Channel Hold Controller

This block handles the short exchange that follows a frame on a shared single-wire or radio channel. On the sending side, once a frame has left the transmitter, the block keeps the channel looking occupied so that other stations do not start talking. It does this by driving a brief high pulse, half as long as a padding bit, and then leaving the line low for a listening window one padding bit plus one data bit long. The cycle repeats until an answer arrives or the application's response deadline runs out.

On the receiving side, the same block produces the answer. After a good frame, one start strobe makes it drive one extra synchronisation pad on the line: a padding-length high followed by a data-bit-length low. It then asks the padded byte transmitter to send the acknowledgement code. The extra pad lets a waiting sender tell a real reply apart from two stations colliding. Frame checking and frame contents belong to neighbouring blocks. This controller only sees start strobes, the received byte with its valid strobe, and a receive-in-progress indication.

All durations are given in microseconds and turned into clock counts with a clocks-per-microsecond parameter.

Top module: `resp_hold_ctrl`

## Requirements
- R1: After reset the line drive, busy and all result strobes (got_ack, got_nack, timed_out, tx_start) are low.
- R2: A wait_start strobe in idle starts a repeating pattern. The line goes high for PAD_US/2 microseconds, then low for PAD_US+BIT_US microseconds, and the pattern repeats.
- R3: If no response arrives, timed_out pulses for one clock exactly TIMEOUT_US microseconds after the wait_start edge. At that same edge the line is released low and busy falls. The number of high pulses emitted is the whole wait divided by the pattern period, rounded up.
- R4: When rx_active is seen during a listening window, no further pulses are driven. A following rx_valid carrying the byte 6 (ACK_CODE) produces a one-clock got_ack and returns the block to idle with the line low.
- R5: An rx_valid accepted while waiting that carries any byte other than 6 produces a one-clock got_nack and ends the wait.
- R6: If a response byte is accepted on the same clock edge on which the deadline expires, the response is reported and timed_out stays low.
- R7: An ack_send strobe in idle drives the line high for PAD_US microseconds and then low for BIT_US microseconds. It then raises tx_start for one clock with tx_byte equal to 6, and holds busy until tx_done.
- R8: wait_start and ack_send are ignored while busy, and rx_valid is ignored while idle. None of these produces an event or a change on the line.
- R9: At most one of got_ack, got_nack, timed_out is high on any clock, and each lasts a single clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wait_start | input | 1 | Frame sent; begin holding the channel and listening |
| ack_send | input | 1 | Good frame received; send sync pad and acknowledgement |
| rx_active | input | 1 | Receiver is inside a byte reception |
| rx_valid | input | 1 | Received byte strobe |
| rx_byte | input | 8 | Received byte value |
| tx_done | input | 1 | Padded transmitter finished the requested byte |
| line_hi | output | 1 | Line drive, high when set |
| tx_start | output | 1 | One-clock request to the padded transmitter |
| tx_byte | output | 8 | Byte to transmit (acknowledgement code) |
| busy | output | 1 | Block is waiting or responding |
| got_ack | output | 1 | One-clock strobe: acknowledgement received |
| got_nack | output | 1 | One-clock strobe: other byte received |
| timed_out | output | 1 | One-clock strobe: response deadline expired |

## Verification
On every clock the assertions check several things. The result strobes are mutually exclusive and last one clock. The line is never held high longer than a full padding bit. Every ending releases the line and drops busy. A byte arriving while idle leaves no result behind. The exact durations can only be shown by the bench scenarios: the half-pad pulse, the listening window, the deadline, and the pad-then-gap before tx_start. The same holds for the pulse count over a full timeout, the suppression of pulses while a reply is arriving, and the outcome when a reply lands on the expiry edge.

// File: rtl/resp_hold_ctrl.sv
module resp_hold_ctrl #(
  parameter int CLK_PER_US = 125,
  parameter int PAD_US = 328,
  parameter int BIT_US = 512,
  parameter int TIMEOUT_US = 20000,
  parameter logic [7:0] ACK_CODE = 8'd6
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wait_start,
  input  logic       ack_send,
  input  logic       rx_active,
  input  logic       rx_valid,
  input  logic [7:0] rx_byte,
  input  logic       tx_done,
  output logic       line_hi,
  output logic       tx_start,
  output logic [7:0] tx_byte,
  output logic       busy,
  output logic       got_ack,
  output logic       got_nack,
  output logic       timed_out
);

  localparam int PULSE_CYC  = (PAD_US / 2) * CLK_PER_US;
  localparam int LISTEN_CYC = (PAD_US + BIT_US) * CLK_PER_US;
  localparam int PAD_CYC    = PAD_US * CLK_PER_US;
  localparam int BIT_CYC    = BIT_US * CLK_PER_US;
  localparam int TO_CYC     = TIMEOUT_US * CLK_PER_US;
  localparam int PW = $clog2(LISTEN_CYC + 1);
  localparam int TW = $clog2(TO_CYC + 1);
  localparam logic [PW-1:0] PULSE_END  = PW'(PULSE_CYC - 1);
  localparam logic [PW-1:0] LISTEN_END = PW'(LISTEN_CYC - 1);
  localparam logic [PW-1:0] PAD_END    = PW'(PAD_CYC - 1);
  localparam logic [PW-1:0] BIT_END    = PW'(BIT_CYC - 1);
  localparam logic [TW-1:0] TO_END     = TW'(TO_CYC - 1);

  typedef enum logic [2:0] {
    S_IDLE, S_PULSE, S_LISTEN, S_RECV, S_RPAD, S_RGAP, S_RSTART, S_RWAIT
  } st_t;

  st_t st;
  logic [PW-1:0] ph;
  logic [TW-1:0] tc;

  wire waiting = (st == S_PULSE) || (st == S_LISTEN) || (st == S_RECV);
  wire resp_ok = rx_valid && ((st == S_LISTEN) || (st == S_RECV));
  wire expire  = waiting && (tc == TO_END);

  assign line_hi  = (st == S_PULSE) || (st == S_RPAD);
  assign tx_start = (st == S_RSTART);
  assign tx_byte  = ACK_CODE;
  assign busy     = (st != S_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      ph <= '0;
      tc <= '0;
      got_ack <= 1'b0;
      got_nack <= 1'b0;
      timed_out <= 1'b0;
    end else begin
      got_ack <= 1'b0;
      got_nack <= 1'b0;
      timed_out <= 1'b0;
      ph <= ph + 1'b1;
      if (waiting) tc <= tc + 1'b1;
      case (st)
        S_IDLE: begin
          ph <= '0;
          if (wait_start) begin
            st <= S_PULSE;
            tc <= '0;
          end else if (ack_send) begin
            st <= S_RPAD;
          end
        end
        S_PULSE:
          if (ph == PULSE_END) begin
            st <= S_LISTEN;
            ph <= '0;
          end
        S_LISTEN:
          if (rx_active) st <= S_RECV;
          else if (ph == LISTEN_END) begin
            st <= S_PULSE;
            ph <= '0;
          end
        S_RECV: ;
        S_RPAD:
          if (ph == PAD_END) begin
            st <= S_RGAP;
            ph <= '0;
          end
        S_RGAP:
          if (ph == BIT_END) st <= S_RSTART;
        S_RSTART: st <= S_RWAIT;
        S_RWAIT:  if (tx_done) st <= S_IDLE;
        default:  st <= S_IDLE;
      endcase
      if (resp_ok) begin
        st <= S_IDLE;
        got_ack  <= (rx_byte == ACK_CODE);
        got_nack <= (rx_byte != ACK_CODE);
      end else if (expire) begin
        st <= S_IDLE;
        timed_out <= 1'b1;
      end
    end
  end

  localparam int HW = $clog2(PAD_CYC + 2);
  logic [HW-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (!rst_n) hi_run <= '0;
    else if (!line_hi) hi_run <= '0;
    else if (hi_run != '1) hi_run <= hi_run + 1'b1;
  end

  // R2
  hi_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hi_run <= HW'(PAD_CYC));

  // R9
  one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({got_ack, got_nack, timed_out}));

  // R9
  short_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (got_ack || got_nack || timed_out) |=> !(got_ack || got_nack || timed_out));

  // R3
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (got_ack || got_nack || timed_out) |-> (!line_hi && !busy));

  // R8
  idle_rx_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && rx_valid) |=> !(got_ack || got_nack));

  // R7
  txs_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_start |=> (!tx_start && busy && !line_hi));

endmodule

// File: tb/sim_resp_hold_ctrl.sv
module sim_resp_hold_ctrl;
  localparam int PAD = 328, BITT = 512, TO = 3500;
  localparam int PULSE = PAD / 2, LISTEN = PAD + BITT;
  localparam logic [3:0] E_ACK = 4'b0001, E_NACK = 4'b0010, E_TO = 4'b0100, E_TXS = 4'b1000;

  logic clk = 0, rst_n = 0;
  logic wait_start = 0, ack_send = 0, rx_active = 0, rx_valid = 0, tx_done = 0;
  logic [7:0] rx_byte = 0;
  logic line_hi, tx_start, busy, got_ack, got_nack, timed_out;
  logic [7:0] tx_byte;

  always #4 clk = ~clk;

  resp_hold_ctrl #(.CLK_PER_US(1), .TIMEOUT_US(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .wait_start(wait_start), .ack_send(ack_send),
    .rx_active(rx_active), .rx_valid(rx_valid), .rx_byte(rx_byte), .tx_done(tx_done),
    .line_hi(line_hi), .tx_start(tx_start), .tx_byte(tx_byte), .busy(busy),
    .got_ack(got_ack), .got_nack(got_nack), .timed_out(timed_out));

  int tests = 0, fails = 0;
  logic [3:0] exp_q[$];

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      logic [3:0] ev;
      ev = {tx_start, timed_out, got_nack, got_ack};
      if (ev != 0) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected event", ev, 0);
        else begin
          logic [3:0] e;
          e = exp_q.pop_front();
          chk(ev == e, "R9 event match", ev, e);
        end
      end
    end
  end

  task automatic start_wait();
    wait_start = 1; tick(); wait_start = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk({line_hi, busy, got_ack, got_nack, timed_out, tx_start} == 0, "R1 reset outputs",
        {line_hi, busy, got_ack, got_nack, timed_out, tx_start}, 0);
    rst_n = 1;
    tick();

    // R2 / R3: full timeout run
    begin
      int fall_at = 0, rise2_at = 0, to_at = 0, rises = 0;
      bit prev = 0;
      exp_q.push_back(E_TO);
      start_wait();
      for (int n = 1; n <= TO + 20; n++) begin
        if (line_hi && !prev) begin rises++; if (rises == 2) rise2_at = n; end
        if (!line_hi && prev && fall_at == 0) fall_at = n;
        if (timed_out && to_at == 0) begin
          to_at = n;
          chk(!line_hi && !busy, "R3 line released at expiry", {line_hi, busy}, 0);
        end
        prev = line_hi;
        tick();
      end
      chk(fall_at == PULSE + 1, "R2 half-pad pulse width", fall_at - 1, PULSE);
      chk(rise2_at - fall_at == LISTEN, "R2 listen window", rise2_at - fall_at, LISTEN);
      chk(to_at == TO + 1, "R3 timeout instant", to_at, TO + 1);
      chk(rises == (TO + PULSE + LISTEN - 1) / (PULSE + LISTEN), "R3 pulse count", rises,
          (TO + PULSE + LISTEN - 1) / (PULSE + LISTEN));
    end

    // R4: reply in progress suppresses pulses, then ACK; R8: ack_send while waiting ignored
    begin
      int highs = 0;
      start_wait();
      repeat (20) tick();
      ack_send = 1; tick(); ack_send = 0;
      repeat (PULSE + 10 - 22) tick();
      rx_active = 1;
      for (int n = 0; n < LISTEN + 200; n++) begin highs += line_hi; tick(); end
      chk(highs == 0, "R4 no pulses during reception", highs, 0);
      rx_active = 0;
      rx_valid = 1; rx_byte = 8'd6;
      exp_q.push_back(E_ACK);
      tick();
      rx_valid = 0;
      chk(got_ack && !busy, "R4 ack reported", {got_ack, busy}, 2);
      highs = 0;
      for (int n = 0; n < 1200; n++) begin highs += line_hi; tick(); end
      chk(highs == 0 && !busy, "R4 line stays low after ack", highs, 0);
    end

    // R5: other byte gives a negative result
    start_wait();
    repeat (PULSE + 50) tick();
    rx_valid = 1; rx_byte = 8'h15;
    exp_q.push_back(E_NACK);
    tick();
    rx_valid = 0;
    chk(got_nack && !got_ack && !busy, "R5 nack reported", {got_nack, got_ack, busy}, 4);
    repeat (10) tick();

    // R6: response on the expiry edge
    start_wait();
    repeat (TO - 1) tick();
    rx_valid = 1; rx_byte = 8'd6;
    exp_q.push_back(E_ACK);
    tick();
    rx_valid = 0;
    chk(got_ack && !timed_out, "R6 response beats expiry", {got_ack, timed_out}, 2);
    repeat (TO + 10) tick();
    chk(!busy && exp_q.size() == 0, "R6 no late timeout", exp_q.size(), 0);

    // R7: responder pad, gap, byte request; R8: wait_start while responding ignored
    begin
      int hi = 0, lo = 0, highs = 0;
      bit seen = 0;
      exp_q.push_back(E_TXS);
      ack_send = 1; tick(); ack_send = 0;
      for (int n = 0; n < PAD + BITT + 20 && !seen; n++) begin
        if (tx_start) begin
          seen = 1;
          chk(tx_byte == 8'd6, "R7 ack byte value", tx_byte, 6);
        end else if (line_hi) hi++;
        else lo++;
        tick();
      end
      chk(seen, "R7 tx_start issued", seen, 1);
      chk(hi == PAD, "R7 sync pad high", hi, PAD);
      chk(lo == BITT, "R7 sync pad low", lo, BITT);
      repeat (10) tick();
      wait_start = 1; tick(); wait_start = 0;
      for (int n = 0; n < 20; n++) begin highs += line_hi; tick(); end
      chk(busy && highs == 0, "R8 wait_start ignored while responding", highs, 0);
      tx_done = 1; tick(); tx_done = 0;
      chk(!busy, "R7 busy released on tx_done", busy, 0);
      highs = 0;
      for (int n = 0; n < 400; n++) begin highs += line_hi; tick(); end
      chk(highs == 0 && !busy, "R8 no deferred start", highs, 0);
    end

    // R8: byte in idle
    rx_valid = 1; rx_byte = 8'd6; tick(); rx_valid = 0;
    chk(!got_ack && !got_nack && !busy, "R8 idle byte ignored", {got_ack, got_nack, busy}, 0);
    repeat (5) tick();

    chk(exp_q.size() == 0, "R9 all expected events seen", exp_q.size(), 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule